// File: doc/BRIEF.md
# Two-Level Preemptive Interrupt Arbiter

This block chooses which of several interrupt sources a small CPU sequencer should service next. Each source has three controls: an enable, a priority bit (low or high) and a type bit (level or edge). Every system clock the block samples the raw requests into pending state and works out a winner. Enabled high-priority sources beat low-priority ones. Within one level, the lowest index wins. The winning index is offered to the CPU through a single valid/ready handshake.

Two in-service bits record which levels have a handler running. When a low handler is active, only a high request can cut in. When a high handler is active, nothing can. The CPU signals the end of a handler with a return strobe, which clears the highest in-service bit that is set. After every return, the CPU must also signal that one further instruction has completed before the block will offer another vector. A stall input holds back new vectors without losing any pending request. Instruction execution and call timing are not modelled here: the CPU represents them only through the strobes.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, no vector is offered (`vec_valid` low), no handler is in service and no edge flag is pending.
- R2: A request is first registered, then arbitrated. `vec_valid` rises on the second rising clock edge after the request is asserted, and not on the first. This holds for both level and edge sources.
- R3: A source whose enable bit is 0 is never offered as a vector.
- R4: When high- and low-priority requests (`src_hi` bit 1 means high) are pending together, the high one is offered and `vec_hi` is 1.
- R5: Among pending requests of the same priority, the lowest index is offered.
- R6: While only a low-priority handler is in service, a pending high-priority request is offered.
- R7: While a high-priority handler is in service, no vector is offered.
- R8: While a low-priority handler is in service, no low-priority vector is offered.
- R9: A `reti` pulse clears the high in-service bit if it is set, and otherwise the low one. After any `reti`, no vector is offered until an `insn_done` pulse has been seen.
- R10: While `stall` is high, no new vector is offered. Requests that arrive during a stall are kept, and the first cycle without stall can issue one of them.
- R11: Once offered, a vector keeps `vec_valid`, `vec_idx` and `vec_hi` unchanged until it is accepted (`vec_valid` and `vec_ready` both high on a clock edge).
- R12: An edge source (`src_edge` bit 1) latches a rising edge of its request as a pending flag. Accepting that source's vector clears the flag. A level source (`src_edge` bit 0) stays pending for as long as its request input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N_SRC | Raw interrupt request per source |
| src_en | input | N_SRC | Enable per source |
| src_hi | input | N_SRC | Priority per source, 1 = high |
| src_edge | input | N_SRC | Type per source, 1 = rising-edge, 0 = level |
| stall | input | 1 | Holds off issue of a new vector |
| reti | input | 1 | Return-from-handler strobe |
| insn_done | input | 1 | Instruction-complete strobe |
| vec_ready | input | 1 | CPU accepts the offered vector |
| vec_valid | output | 1 | A vector is offered |
| vec_idx | output | $clog2(N_SRC) | Index of the offered source |
| vec_hi | output | 1 | Priority of the offered source |

## Verification
The assertions take for granted that the CPU does not pulse `reti` in the same cycle as it accepts a vector, and that it never pulses `reti` with no handler in service. They also assume that no edge source sees a new rising edge in the cycle its vector is accepted. The bench drives every strobe as a single-cycle pulse on its own, and it sends `reti` only after an accepted vector. In the random phase it uses only level sources and clears their requests at acceptance, so every random case starts from an idle arbiter and its expected winner follows from the enable, priority and request words alone.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;
endpackage

// File: rtl/irq_pending.sv
// Samples raw requests and keeps per-source pending state.
module irq_pending #(
  parameter int N_SRC = 8,
  localparam int IW = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] src_edge,
  input  logic             ack,
  input  logic [IW-1:0]    ack_idx,
  output logic [N_SRC-1:0] pend
);
  logic [N_SRC-1:0] req_q;
  logic [N_SRC-1:0] edge_flag;

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= src_req;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)
        edge_flag[i] <= 1'b0;
      else if (src_req[i] && !req_q[i])
        edge_flag[i] <= 1'b1;
      else if (ack && ack_idx == IW'(i))
        edge_flag[i] <= 1'b0;
    end
    assign pend[i] = src_edge[i] ? edge_flag[i] : req_q[i];
  end

  // R12: accepting an edge source drops its flag
  p_edge_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (ack && !src_req[ack_idx]) |=> !edge_flag[$past(ack_idx)]);

  // R1: nothing pending right after reset
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (edge_flag == '0 && req_q == '0));
endmodule

// File: rtl/irq_pick.sv
// Lowest-index winner among a candidate set.
module irq_pick #(
  parameter int N_SRC = 8,
  localparam int IW = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] cand,
  output logic             found,
  output logic [IW-1:0]    idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  always_comb begin
    if (found) a_pick_valid_r5: assert (cand[idx]);
  end
endmodule

// File: rtl/irq_nest.sv
// In-service bits per level and the post-return instruction gate.
module irq_nest (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  input  logic ack_hi,
  input  logic reti,
  input  logic insn_done,
  output logic isr_hi,
  output logic isr_lo,
  output logic gate
);
  always_ff @(posedge clk) begin
    if (rst) begin
      isr_hi <= 1'b0;
      isr_lo <= 1'b0;
    end else if (ack) begin
      if (ack_hi) isr_hi <= 1'b1;
      else        isr_lo <= 1'b1;
    end else if (reti) begin
      if (isr_hi) isr_hi <= 1'b0;
      else        isr_lo <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            gate <= 1'b0;
    else if (reti)      gate <= 1'b1;
    else if (insn_done) gate <= 1'b0;
  end

  p_reti_top_r9: assert property (@(posedge clk) disable iff (rst)
    (reti && !ack && isr_hi) |=> (!isr_hi && isr_lo == $past(isr_lo)));

  p_reti_low_r9: assert property (@(posedge clk) disable iff (rst)
    (reti && !ack && !isr_hi) |=> !isr_lo);

  p_gate_set_r9: assert property (@(posedge clk) disable iff (rst)
    reti |=> gate);

  p_ack_level_r6: assert property (@(posedge clk) disable iff (rst)
    (ack && ack_hi) |=> isr_hi);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC = 8,
  localparam int IW = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] src_hi,
  input  logic [N_SRC-1:0] src_edge,
  input  logic             stall,
  input  logic             reti,
  input  logic             insn_done,
  input  logic             vec_ready,
  output logic             vec_valid,
  output logic [IW-1:0]    vec_idx,
  output logic             vec_hi
);
  import irq_arb_pkg::*;

  logic [N_SRC-1:0] pend, elig, cand_hi, cand_lo;
  logic             found_hi, found_lo;
  logic [IW-1:0]    idx_hi, idx_lo;
  logic             isr_hi, isr_lo, gate;
  logic             take_hi, take_lo, can_issue, ack;
  lvl_e             vec_lvl;

  assign ack = vec_valid && vec_ready;

  irq_pending #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst(rst), .src_req(src_req), .src_edge(src_edge),
    .ack(ack), .ack_idx(vec_idx), .pend(pend)
  );

  assign elig    = pend & src_en;
  assign cand_hi = elig & src_hi;
  assign cand_lo = elig & ~src_hi;

  irq_pick #(.N_SRC(N_SRC)) u_pick_hi (.cand(cand_hi), .found(found_hi), .idx(idx_hi));
  irq_pick #(.N_SRC(N_SRC)) u_pick_lo (.cand(cand_lo), .found(found_lo), .idx(idx_lo));

  irq_nest u_nest (
    .clk(clk), .rst(rst), .ack(ack), .ack_hi(vec_hi), .reti(reti),
    .insn_done(insn_done), .isr_hi(isr_hi), .isr_lo(isr_lo), .gate(gate)
  );

  assign take_hi   = !isr_hi && found_hi;
  assign take_lo   = !take_hi && !isr_hi && !isr_lo && found_lo;
  assign can_issue = !vec_valid && !stall && !gate && (take_hi || take_lo);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid <= 1'b0;
      vec_idx   <= '0;
      vec_lvl   <= LVL_LO;
    end else if (ack) begin
      vec_valid <= 1'b0;
    end else if (can_issue) begin
      vec_valid <= 1'b1;
      vec_idx   <= take_hi ? idx_hi : idx_lo;
      vec_lvl   <= take_hi ? LVL_HI : LVL_LO;
    end
  end

  assign vec_hi = (vec_lvl == LVL_HI);

  logic [N_SRC-1:0] en_d;
  always_ff @(posedge clk) begin
    if (rst) en_d <= '0;
    else     en_d <= src_en;
  end

  p_enabled_only_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_valid) |-> en_d[vec_idx]);

  p_hold_offer_r11: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_idx) && $stable(vec_hi)));

  p_hi_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (!vec_valid && isr_hi) |=> !vec_valid);

  p_lo_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (!vec_valid && isr_lo) |=> (!vec_valid || vec_hi));

  p_gate_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!vec_valid && gate) |=> !vec_valid);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!vec_valid && stall) |=> !vec_valid);
endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] src_req, src_en, src_hi, src_edge;
  logic stall, reti, insn_done, vec_ready;
  logic vec_valid, vec_hi;
  logic [IW-1:0] vec_idx;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_arbiter #(.N_SRC(N)) u0 (
    .clk(clk), .rst(rst), .src_req(src_req), .src_en(src_en), .src_hi(src_hi),
    .src_edge(src_edge), .stall(stall), .reti(reti), .insn_done(insn_done),
    .vec_ready(vec_ready), .vec_valid(vec_valid), .vec_idx(vec_idx), .vec_hi(vec_hi)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_vec(input string req, input int idx);
    chk(vec_valid === 1'b1, req, int'(vec_valid), 1);
    chk(int'(vec_idx) == idx, req, int'(vec_idx), idx);
  endtask

  task automatic ack_vec();
    vec_ready = 1'b1; step(1); vec_ready = 1'b0;
  endtask
  task automatic pulse_reti();
    reti = 1'b1; step(1); reti = 1'b0;
  endtask
  task automatic pulse_insn();
    insn_done = 1'b1; step(1); insn_done = 1'b0;
  endtask
  task automatic retire();
    src_req = '0; ack_vec(); pulse_reti(); pulse_insn(); step(2);
  endtask

  function automatic int exp_win(input logic [N-1:0] rq, input logic [N-1:0] en,
                                 input logic [N-1:0] hi);
    logic [N-1:0] e;
    e = rq & en;
    for (int i = 0; i < N; i++) if (e[i] && hi[i]) return i;
    for (int i = 0; i < N; i++) if (e[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    rst = 1'b1; src_req = '0; src_en = '0; src_hi = '0; src_edge = '0;
    stall = 1'b0; reti = 1'b0; insn_done = 1'b0; vec_ready = 1'b0;
    step(3); rst = 1'b0; step(1);
    chk(vec_valid === 1'b0, "R1 idle after reset", int'(vec_valid), 0);

    src_en = '1;
    // R2 edge source latency, R11 hold, R12 flag cleared
    src_edge[3] = 1'b1;
    src_req[3] = 1'b1; step(1); src_req[3] = 1'b0;
    chk(vec_valid === 1'b0, "R2 not on first edge", int'(vec_valid), 0);
    step(1);
    chk_vec("R2 edge source offered", 3);
    step(3);
    chk_vec("R11 held while not ready", 3);
    retire(); step(2);
    chk(vec_valid === 1'b0, "R12 edge flag cleared on accept", int'(vec_valid), 0);

    // R12 level source stays pending
    src_req[4] = 1'b1; step(2);
    chk_vec("R2 level source offered", 4);
    ack_vec(); pulse_reti(); pulse_insn(); step(1);
    chk_vec("R12 level source re-offered", 4);
    retire();

    // R4 high over low
    src_hi[4] = 1'b1; src_req[1] = 1'b1; src_req[4] = 1'b1; step(2);
    chk_vec("R4 high wins", 4);
    chk(vec_hi === 1'b1, "R4 vec_hi", int'(vec_hi), 1);
    retire(); src_hi = '0;

    // R5 lowest index within level
    src_req[2] = 1'b1; src_req[5] = 1'b1; step(2);
    chk_vec("R5 lowest index", 2);
    retire();

    // R3 disabled source masked
    src_en[0] = 1'b0; src_req[0] = 1'b1; step(3);
    chk(vec_valid === 1'b0, "R3 disabled ignored", int'(vec_valid), 0);
    src_req[0] = 1'b0; step(2); src_en[0] = 1'b1; step(1);

    // R6, R7, R8, R9 nesting
    src_hi[6] = 1'b1; src_hi[7] = 1'b1;
    src_req[5] = 1'b1; step(2);
    chk_vec("R8 low offered when idle", 5);
    vec_ready = 1'b1; src_req[5] = 1'b0; step(1); vec_ready = 1'b0;
    src_req[2] = 1'b1; step(3);
    chk(vec_valid === 1'b0, "R8 low waits behind low", int'(vec_valid), 0);
    src_req[6] = 1'b1; step(2);
    chk_vec("R6 high preempts low", 6);
    vec_ready = 1'b1; src_req[6] = 1'b0; step(1); vec_ready = 1'b0;
    src_req[7] = 1'b1; step(3);
    chk(vec_valid === 1'b0, "R7 nothing during high", int'(vec_valid), 0);
    pulse_reti(); step(2);
    chk(vec_valid === 1'b0, "R9 gate after return", int'(vec_valid), 0);
    pulse_insn(); step(1);
    chk_vec("R9 issue after instruction", 7);
    vec_ready = 1'b1; src_req[7] = 1'b0; step(1); vec_ready = 1'b0;
    pulse_reti(); pulse_insn(); step(2);
    chk(vec_valid === 1'b0, "R9 low still in service", int'(vec_valid), 0);
    pulse_reti(); pulse_insn(); step(1);
    chk_vec("R9 low level cleared", 2);
    retire(); src_hi = '0;

    // R10 stall
    src_edge[1] = 1'b1; stall = 1'b1;
    src_req[1] = 1'b1; step(1); src_req[1] = 1'b0; step(4);
    chk(vec_valid === 1'b0, "R10 held by stall", int'(vec_valid), 0);
    stall = 1'b0; step(1);
    chk_vec("R10 kept across stall", 1);
    retire(); src_edge = '0;

    // random level patterns: R3 R4 R5
    for (int k = 0; k < 60; k++) begin
      logic [N-1:0] rq, en, hi;
      int w;
      rq = N'($urandom); en = N'($urandom); hi = N'($urandom);
      src_en = en; src_hi = hi; src_req = rq;
      w = exp_win(rq, en, hi);
      step(2);
      if (w >= 0) begin
        chk_vec("R4 R5 random winner", w);
        chk(vec_hi === hi[w], "R4 random level", int'(vec_hi), int'(hi[w]));
        retire();
      end else begin
        chk(vec_valid === 1'b0, "R3 random none eligible", int'(vec_valid), 0);
        src_req = '0; step(2);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule